// File: doc/BRIEF.md
# Chainable Event Counter Bank

The block is a small performance-monitoring bank. It holds a parameterised number of counters, eight by default, and each counter is 16 bits wide. Each counter watches one line of a vector of single-cycle event pulses. Software picks that line by writing an 8-bit selector. On every clock edge where the chosen line is high and counting is allowed, the counter advances by one.

Neighbouring counters form pairs (0,1), (2,3) and so on. When a pair's link bit is set, the odd member stops watching its own event line. It then advances once each time the even member rolls over from all-ones to zero, so the pair behaves as one 32-bit counter. Rollovers set sticky flags that software clears by writing ones.

All control goes through a flat word-addressed register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `evcnt_unit`

## Requirements
- R1: After reset every counter, selector, enable bit, link bit and overflow flag reads as zero.
- R2: A counter advances by exactly one on each clock edge where the event line addressed by its selector (register 0x10+i, bits 7:0) is high and counting is enabled. Its value (register 0x20+i, bits 15:0) is readable after that edge.
- R3: A counter does not change while the global enable (register 0x00 bit 0) is clear or its own enable (register 0x01 bit i) is clear, whatever its event line does.
- R4: A selector value at or above the number of event lines never causes an increment.
- R5: A rollover from 0xFFFF to 0x0000 sets overflow flag i (register 0x03 bit i). The flag stays set until a one is written to that bit, and writing zero leaves it unchanged.
- R6: With link bit k (register 0x02 bit k) set, counter 2k+1 advances only on a rollover of counter 2k and ignores its own event line.
- R7: In a linked pair, a rollover of the even counter sets no flag, while a rollover of the odd counter sets flag 2k+1.
- R8: A register write to a counter loads the written value on that edge, even if an increment would have happened on the same edge.
- R9: Register reads return only the implemented bits: enables mask to the counter count, links to the pair count, selectors to 8 bits, counters to 16 bits. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | NUM_EVT | Event pulses, one line per event source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |

## Verification
The bench builds the bank with four counters and sixteen event lines. Four rounds of selector assignments then cover every event line, with counts predicted arithmetically from a known pulse pattern. Presetting counters near 0xFFFF makes rollover, sticky-flag clearing and the linked 32-bit carry reachable within a few cycles. A selector of 20 exercises the out-of-range path that the default 256-line build cannot reach.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_GLOBAL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTR_EN  = 6'h01;
  localparam logic [ADDR_W-1:0] A_LINK    = 6'h02;
  localparam logic [ADDR_W-1:0] A_OVF     = 6'h03;
  localparam logic [ADDR_W-1:0] A_SEL_BASE = 6'h10;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 6'h20;
endpackage

// File: rtl/evcnt_rst_sync.sv
module evcnt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/evcnt_slice.sv
module evcnt_slice #(
  parameter int CTR_W   = 16,
  parameter int SEL_W   = 8,
  parameter int NUM_EVT = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  input  logic             linked_i,
  input  logic             carry_i,
  input  logic             wr_i,
  input  logic [CTR_W-1:0] wdata_i,
  output logic [CTR_W-1:0] value_o,
  output logic             wrap_o
);
  logic [CTR_W-1:0] cnt_q, cnt_d;
  logic             hit, step, load_en;

  // event mux: out-of-range selector leaves hit low
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (sel_i == SEL_W'(k)) hit = evt_i[k];
    end
  end

  assign step    = en_i && (linked_i ? carry_i : hit);
  assign load_en = wr_i || step;
  assign wrap_o  = step && !wr_i && (cnt_q == {CTR_W{1'b1}});

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)      cnt_d = wdata_i;
    else if (step) cnt_d = cnt_q + CTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load_en) cnt_q <= cnt_d;
  end

  assign value_o = cnt_q;

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (value_o == $past(wdata_i)));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !en_i) |=> $stable(value_o));
endmodule

// File: rtl/evcnt_regs.sv
module evcnt_regs
  import evcnt_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 16,
  parameter int SEL_W   = 8,
  localparam int NUM_PAIR = NUM_CTR / 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [NUM_CTR-1:0]       ovf_set_i,
  input  logic [NUM_CTR*CTR_W-1:0] cnt_flat_i,
  output logic                     global_en_o,
  output logic [NUM_CTR-1:0]       ctr_en_o,
  output logic [NUM_PAIR-1:0]      link_o,
  output logic [NUM_CTR*SEL_W-1:0] sel_flat_o,
  output logic [NUM_CTR-1:0]       ovf_o,
  output logic [DATA_W-1:0]        rdata_o
);
  logic                 glb_q, glb_d;
  logic [NUM_CTR-1:0]   en_q, en_d;
  logic [NUM_PAIR-1:0]  link_q, link_d;
  logic [NUM_CTR-1:0]   ovf_q, ovf_d, clr_mask;
  logic                 ctl_we;

  assign ctl_we   = we_i && (addr_i == A_GLOBAL || addr_i == A_CTR_EN || addr_i == A_LINK);
  assign clr_mask = (we_i && addr_i == A_OVF) ? wdata_i[NUM_CTR-1:0] : '0;

  always_comb begin
    glb_d  = glb_q;
    en_d   = en_q;
    link_d = link_q;
    if (we_i && addr_i == A_GLOBAL) glb_d  = wdata_i[0];
    if (we_i && addr_i == A_CTR_EN) en_d   = wdata_i[NUM_CTR-1:0];
    if (we_i && addr_i == A_LINK)   link_d = wdata_i[NUM_PAIR-1:0];
    ovf_d = (ovf_q & ~clr_mask) | ovf_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q  <= 1'b0;
      en_q   <= '0;
      link_q <= '0;
    end else if (ctl_we) begin
      glb_q  <= glb_d;
      en_q   <= en_d;
      link_q <= link_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= ovf_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CTR; gi++) begin : g_sel
      localparam logic [ADDR_W-1:0] MY_ADDR = A_SEL_BASE + ADDR_W'(gi);
      logic [SEL_W-1:0] sel_q;
      logic             sel_we;
      assign sel_we = we_i && (addr_i == MY_ADDR);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_we) sel_q <= wdata_i[SEL_W-1:0];
      end
      assign sel_flat_o[gi*SEL_W +: SEL_W] = sel_q;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_GLOBAL) rdata_o[0] = glb_q;
    if (addr_i == A_CTR_EN) rdata_o[NUM_CTR-1:0] = en_q;
    if (addr_i == A_LINK)   rdata_o[NUM_PAIR-1:0] = link_q;
    if (addr_i == A_OVF)    rdata_o[NUM_CTR-1:0] = ovf_q;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (addr_i == A_SEL_BASE + ADDR_W'(i)) rdata_o[SEL_W-1:0] = sel_flat_o[i*SEL_W +: SEL_W];
      if (addr_i == A_CNT_BASE + ADDR_W'(i)) rdata_o[CTR_W-1:0] = cnt_flat_i[i*CTR_W +: CTR_W];
    end
  end

  assign global_en_o = glb_q;
  assign ctr_en_o    = en_q;
  assign link_o      = link_q;
  assign ovf_o       = ovf_q;

  // R5
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_q & $past(ovf_q & ~clr_mask)) == $past(ovf_q & ~clr_mask)));
endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit
  import evcnt_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 16,
  parameter int SEL_W   = 8,
  parameter int NUM_EVT = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               reg_we_i,
  input  logic [5:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o
);
  localparam int NUM_PAIR = NUM_CTR / 2;

  logic                     rst_s_n;
  logic                     global_en;
  logic [NUM_CTR-1:0]       ctr_en, ovf, ovf_set, wrap;
  logic [NUM_PAIR-1:0]      link;
  logic [NUM_CTR*SEL_W-1:0] sel_flat;
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;

  evcnt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  evcnt_regs #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .ovf_set_i(ovf_set), .cnt_flat_i(cnt_flat),
    .global_en_o(global_en), .ctr_en_o(ctr_en), .link_o(link),
    .sel_flat_o(sel_flat), .ovf_o(ovf), .rdata_o(reg_rdata_o)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
      localparam logic [ADDR_W-1:0] MY_ADDR = A_CNT_BASE + ADDR_W'(gi);
      logic linked, carry, wr;
      assign wr = reg_we_i && (reg_addr_i == MY_ADDR);
      if (gi % 2 == 1) begin : g_upper
        assign linked      = link[gi/2];
        assign carry       = wrap[gi-1];
        assign ovf_set[gi] = wrap[gi];
        // R6
        linked_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
          (linked && !wr && !wrap[gi-1]) |=> $stable(cnt_flat[gi*CTR_W +: CTR_W]));
      end else begin : g_lower
        assign linked      = 1'b0;
        assign carry       = 1'b0;
        assign ovf_set[gi] = wrap[gi] && !link[gi/2];
        // R7
        lower_silent_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
          $rose(ovf[gi]) |-> !$past(link[gi/2]));
      end
      evcnt_slice #(.CTR_W(CTR_W), .SEL_W(SEL_W), .NUM_EVT(NUM_EVT)) u_slice (
        .clk(clk), .rst_n(rst_s_n), .evt_i(evt_i),
        .sel_i(sel_flat[gi*SEL_W +: SEL_W]),
        .en_i(global_en && ctr_en[gi]), .linked_i(linked), .carry_i(carry),
        .wr_i(wr), .wdata_i(reg_wdata_i[CTR_W-1:0]),
        .value_o(cnt_flat[gi*CTR_W +: CTR_W]), .wrap_o(wrap[gi])
      );
    end
  endgenerate
endmodule

// File: tb/evcnt_unit_tb_top.sv
module evcnt_unit_tb_top;
  localparam int NC = 4;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  evcnt_unit #(.NUM_CTR(NC), .CTR_W(16), .SEL_W(8), .NUM_EVT(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata));

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [NE-1:0] v, input int n);
    for (int c = 0; c < n; c++) begin @(negedge clk); evt = v; end
    @(negedge clk); evt = '0;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int c);
    return 16'(c * 40503 + 4951) ^ 16'(c << 5);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(6'(a), r); chk("R1 ctl", r, 0); end
    for (int i = 0; i < NC; i++) begin
      rd(6'h10 + 6'(i), r); chk("R1 sel", r, 0);
      rd(6'h20 + 6'(i), r); chk("R1 cnt", r, 0);
    end

    // R2 sweep over all event lines in four rounds
    wr(6'h00, 1); wr(6'h01, 32'hF);
    for (int rnd = 0; rnd < 4; rnd++) begin
      int exp [NC];
      for (int i = 0; i < NC; i++) begin
        wr(6'h10 + 6'(i), 32'(rnd * 4 + i)); wr(6'h20 + 6'(i), 0); exp[i] = 0;
      end
      for (int c = 0; c < 37; c++) begin
        @(negedge clk); evt = pat(c + rnd * 50);
        for (int i = 0; i < NC; i++) exp[i] += int'(pat(c + rnd * 50) >> (rnd * 4 + i)) & 1;
      end
      @(negedge clk); evt = '0;
      for (int i = 0; i < NC; i++) begin rd(6'h20 + 6'(i), r); chk("R2 count", r, 32'(exp[i])); end
    end

    // R3 enables
    for (int i = 0; i < NC; i++) wr(6'h20 + 6'(i), 0);
    wr(6'h00, 0);
    pulse('1, 5);
    rd(6'h20, r); chk("R3 global off", r, 0);
    wr(6'h00, 1); wr(6'h01, 32'hD);
    pulse('1, 4);
    rd(6'h20, r); chk("R3 enabled", r, 4);
    rd(6'h21, r); chk("R3 local off", r, 0);

    // R4 out-of-range selector
    wr(6'h01, 32'hF); wr(6'h12, 20); wr(6'h22, 0); wr(6'h23, 0);
    pulse('1, 6);
    rd(6'h22, r); chk("R4 sel 20", r, 0);
    rd(6'h23, r); chk("R4 neighbour", r, 6);

    // R5 rollover and sticky flag
    wr(6'h10, 0); wr(6'h20, 32'hFFFE); wr(6'h03, 32'hF);
    pulse(16'h0001, 3);
    rd(6'h20, r); chk("R5 wrapped value", r, 1);
    rd(6'h03, r); chk("R5 flag set", r & 1, 1);
    wr(6'h03, 0);
    rd(6'h03, r); chk("R5 write zero keeps", r & 1, 1);
    wr(6'h03, 1);
    rd(6'h03, r); chk("R5 w1c", r & 1, 0);

    // R6 / R7 linked pair
    wr(6'h02, 1); wr(6'h11, 1); wr(6'h20, 32'hFFFD); wr(6'h21, 5); wr(6'h03, 32'hF);
    pulse('1, 5);
    rd(6'h20, r); chk("R6 lower", r, 2);
    rd(6'h21, r); chk("R6 upper carry", r, 6);
    rd(6'h03, r); chk("R7 lower no flag", r & 3, 0);
    wr(6'h20, 32'hFFFF); wr(6'h21, 32'hFFFF);
    pulse('1, 1);
    rd(6'h20, r); chk("R6 lower wrap", r, 0);
    rd(6'h21, r); chk("R6 upper wrap", r, 0);
    rd(6'h03, r); chk("R7 upper flag only", r & 3, 2);

    // R8 write beats increment on the same edge
    @(negedge clk); evt = '1; we = 1'b1; addr = 6'h23; wdata = 32'h1234;
    @(negedge clk); we = 1'b0; evt = '0;
    rd(6'h23, r); chk("R8 write wins", r, 32'h1234);
    pulse('1, 1);
    rd(6'h23, r); chk("R2 after write", r, 32'h1235);

    // R9 register field masks
    wr(6'h01, 32'hFFFFFFFF); rd(6'h01, r); chk("R9 enable mask", r, 32'hF);
    wr(6'h02, 32'hFFFFFFFF); rd(6'h02, r); chk("R9 link mask", r, 32'h3);
    wr(6'h00, 32'hFFFFFFFF); rd(6'h00, r); chk("R9 global mask", r, 1);
    wr(6'h11, 32'h0000ABCD); rd(6'h11, r); chk("R9 sel mask", r, 32'hCD);
    wr(6'h20, 32'h5A5A1234); rd(6'h20, r); chk("R9 cnt mask", r, 32'h1234);
    rd(6'h3F, r); chk("R9 unmapped", r, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule